// File: doc/BRIEF.md
# Dual-Mode SPI Serial-Clock Divider

This block turns the module clock into the serial-clock timing of an SPI shift engine. One configuration word selects between two ways of dividing. The linear scheme divides by any even number from 2 to 512. The power-of-two scheme divides by 2 raised to a 4-bit exponent. When the exponent is zero, the module clock passes through undivided.

The block produces three outputs:
- a 50% duty serial-clock level;
- a one-cycle strobe on every rising edge of that level;
- a one-cycle strobe on every falling edge, which the shift engine uses to launch and capture bits.

Software writes the configuration word through a simple write-enable and data port. While the bus is running, a new setting waits for the end of the current serial-clock period, so no shortened pulse ever reaches the pins. While the bus is disabled, the divider is held in reset and the serial clock rests low.

Top module: `spi_sclk_divider`

## Requirements
- R1: The configuration word holds the linear divide value N in bits 7:0, the exponent E in bits 11:8 and the scheme select in bit 12, where 1 selects linear and 0 selects power-of-two.
- R2: In linear mode, each half of the serial clock lasts N+1 module-clock cycles, giving a period of 2×(N+1). N=0 divides by 2 and N=255 divides by 512.
- R3: In power-of-two mode with E from 1 to 15, each half lasts 2^(E-1) cycles, giving a period of 2^E. The largest exponent, 15, divides by 32768.
- R4: In power-of-two mode with E=0, every enabled cycle meets both of these conditions:
  - the serial-clock level is high;
  - the rising-edge strobe is high.

  The falling-edge strobe stays low. This starts from the first clock edge that samples the bus enable.
- R5: The rising-edge strobe is high for exactly the first cycle of each high level. The falling-edge strobe is high for exactly the first cycle of each low level that follows a high level. While the bus stays enabled, the level never changes without one of the two strobes.
- R6: While the bus is enabled, a configuration written during a period takes effect at the falling edge that ends that period. The high half in progress keeps its old length. A write in the very cycle of that falling edge takes effect at that edge.
- R7: While the bus enable is low, the following all read zero from the next clock edge on:
  - the serial-clock level;
  - both strobes.

  The divider counter is also held at zero. A configuration written meanwhile is applied at the next edge and does not start the clock.
- R8: After reset, the serial-clock level and both strobes are low. The active configuration is all zeros, which is power-of-two mode with E=0.
- R9: Only the field named by the scheme select sets the divide. The other field has no effect on the output timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus enable; when low, the divider is held at its idle state |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 13 | Configuration word: N, E and the scheme select |
| sclk_o | output | 1 | Serial-clock level, 50% duty when dividing |
| sclk_lead_o | output | 1 | One-cycle strobe on each rising edge (every cycle in pass-through) |
| sclk_trail_o | output | 1 | One-cycle strobe on each falling edge |

## Verification
Some behaviours are checked on every cycle by the bound assertions:
- the idle state while the bus is disabled;
- the tick on every cycle in pass-through;
- the pairing of each level change with its strobe;
- the counter never passing the half-period limit;
- the rule that the active setting changes only at a period boundary.

Other behaviours can only be shown by the bench scenarios. These are the actual half-period lengths each field value produces, the choice between fields made by the scheme select, and the exact period in which a setting written mid-period first appears. The bench scoreboard measures the time between consecutive strobes and compares each measurement with the expected half-period length.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

  typedef enum logic {
    SCALE_POW2   = 1'b0,
    SCALE_LINEAR = 1'b1
  } scale_mode_e;

  // Last count value of one half period (half length minus one).
  function automatic logic [31:0] half_last_f(logic lin, logic [31:0] n, logic [31:0] e);
    if (lin) return n;
    if (e == 32'd0) return 32'd0;
    return (32'd1 << (e - 32'd1)) - 32'd1;
  endfunction

  // Power-of-two scheme with a zero exponent: no division at all.
  function automatic logic is_pass_f(logic lin, logic [31:0] e);
    return !lin && (e == 32'd0);
  endfunction

  // Counter width able to hold the longest half period of either scheme.
  function automatic int cnt_width_f(int div_w, int exp_w);
    int pow_w;
    pow_w = (1 << exp_w) - 2;
    return (div_w > pow_w) ? div_w : pow_w;
  endfunction

endpackage

// File: rtl/spi_div_cfg_decode.sv
module spi_div_cfg_decode #(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 14,
  localparam int CFG_W = DIV_W + EXP_W + 1
) (
  input  logic [CFG_W-1:0] cfg_i,
  output logic             lin_o,
  output logic             pass_o,
  output logic [CNT_W-1:0] last_o
);
  import spi_div_pkg::*;

  logic [DIV_W-1:0] div_n;
  logic [EXP_W-1:0] exp_e;
  scale_mode_e      scale;

  assign div_n = cfg_i[DIV_W-1:0];
  assign exp_e = cfg_i[DIV_W +: EXP_W];
  assign scale = scale_mode_e'(cfg_i[CFG_W-1]);

  always_comb begin
    lin_o  = (scale == SCALE_LINEAR);
    pass_o = is_pass_f(lin_o, 32'(exp_e));
    last_o = CNT_W'(half_last_f(lin_o, 32'(div_n), 32'(exp_e)));
  end

endmodule

// File: rtl/spi_div_cfg_hold.sv
module spi_div_cfg_hold #(
  parameter int CFG_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             bound_i,
  output logic [CFG_W-1:0] act_cfg_o,
  output logic             pend_o
);
  logic [CFG_W-1:0] pend_cfg_q;
  logic             pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_cfg_o  <= '0;
      pend_cfg_q <= '0;
      pend_v_q   <= 1'b0;
    end else if (wr_en_i && bound_i) begin
      act_cfg_o <= wr_data_i;
      pend_v_q  <= 1'b0;
    end else if (wr_en_i) begin
      pend_cfg_q <= wr_data_i;
      pend_v_q   <= 1'b1;
    end else if (bound_i && pend_v_q) begin
      act_cfg_o <= pend_cfg_q;
      pend_v_q  <= 1'b0;
    end
  end

  assign pend_o = pend_v_q;

endmodule

// File: rtl/spi_div_phase_gen.sv
module spi_div_phase_gen #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pass_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o,
  output logic             bound_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;
  logic             lead_q;
  logic             trail_q;
  logic             at_last;

  assign at_last = (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      lvl_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      lvl_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (pass_i) begin
      cnt_q   <= '0;
      lvl_q   <= 1'b1;
      lead_q  <= 1'b1;
      trail_q <= 1'b0;
    end else if (at_last) begin
      cnt_q   <= '0;
      lvl_q   <= ~lvl_q;
      lead_q  <= ~lvl_q;
      trail_q <= lvl_q;
    end else begin
      cnt_q   <= cnt_q + CNT_W'(1);
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end
  end

  // A period ends on the falling edge; idle and pass-through are always at a boundary.
  assign bound_o = !run_i || pass_i || (at_last && lvl_q);
  assign sclk_o  = lvl_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4,
  localparam int CFG_W = DIV_W + EXP_W + 1,
  localparam int CNT_W = spi_div_pkg::cnt_width_f(DIV_W, EXP_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_en_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             sclk_o,
  output logic             sclk_lead_o,
  output logic             sclk_trail_o
);
  logic [CFG_W-1:0] act_cfg;
  logic             cfg_pending;
  logic             sel_linear;
  logic             pass_thru;
  logic [CNT_W-1:0] half_last;
  logic             period_bound;
  logic [CNT_W-1:0] phase_cnt;

  spi_div_cfg_hold #(.CFG_W(CFG_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cfg_we_i),
    .wr_data_i (cfg_wdata_i),
    .bound_i   (period_bound),
    .act_cfg_o (act_cfg),
    .pend_o    (cfg_pending)
  );

  spi_div_cfg_decode #(.DIV_W(DIV_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_dec (
    .cfg_i  (act_cfg),
    .lin_o  (sel_linear),
    .pass_o (pass_thru),
    .last_o (half_last)
  );

  spi_div_phase_gen #(.CNT_W(CNT_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (bus_en_i),
    .pass_i  (pass_thru),
    .last_i  (half_last),
    .sclk_o  (sclk_o),
    .lead_o  (sclk_lead_o),
    .trail_o (sclk_trail_o),
    .bound_o (period_bound),
    .cnt_o   (phase_cnt)
  );

endmodule

// File: rtl/spi_sclk_divider_chk.sv
module spi_sclk_divider_chk #(
  parameter int CNT_W = 14,
  parameter int CFG_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_en_i,
  input logic             sclk_o,
  input logic             sclk_lead_o,
  input logic             sclk_trail_o,
  input logic             period_bound,
  input logic             pass_thru,
  input logic [CNT_W-1:0] phase_cnt,
  input logic [CNT_W-1:0] half_last,
  input logic [CFG_W-1:0] act_cfg
);

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_en_i |=> (!sclk_o && !sclk_lead_o && !sclk_trail_o)); // R7

  AST_PASS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && pass_thru) |=> (sclk_lead_o && sclk_o && !sclk_trail_o)); // R4

  AST_LEAD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_lead_o |-> sclk_o); // R5

  AST_TRAIL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_trail_o |-> !sclk_o); // R5

  AST_EDGE_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bus_en_i) && (sclk_o != $past(sclk_o))) |-> (sclk_lead_o || sclk_trail_o)); // R5

  AST_CFG_AT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_bound |=> $stable(act_cfg)); // R6

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_cnt <= half_last); // R2

endmodule

bind spi_sclk_divider spi_sclk_divider_chk #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_en_i     (bus_en_i),
  .sclk_o       (sclk_o),
  .sclk_lead_o  (sclk_lead_o),
  .sclk_trail_o (sclk_trail_o),
  .period_bound (period_bound),
  .pass_thru    (pass_thru),
  .phase_cnt    (phase_cnt),
  .half_last    (half_last),
  .act_cfg      (act_cfg)
);

// File: tb/test_spi_sclk_divider.sv
module test_spi_sclk_divider;
  localparam int DIV_W = 8;
  localparam int EXP_W = 4;
  localparam int CFG_W = DIV_W + EXP_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0;
  logic cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic sclk, lead, trail;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_sclk_divider i_spi_sclk_divider (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bus_en_i     (bus_en),
    .cfg_we_i     (cfg_we),
    .cfg_wdata_i  (cfg_wdata),
    .sclk_o       (sclk),
    .sclk_lead_o  (lead),
    .sclk_trail_o (trail)
  );

  // R1 field positions: N in [7:0], E in [11:8], linear select in [12]
  function automatic logic [CFG_W-1:0] enc(bit lin, int e, int n);
    return {lin, EXP_W'(e), DIV_W'(n)};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Monitor: measures half periods between strobes and scores them.
  int  t_lead = 0, t_trail = 0;
  bit  have_lead = 0, have_trail = 0;

  task automatic score(int meas);
    int expv;
    string tag;
    if (exp_q.size() != 0) begin
      expv = exp_q.pop_front();
      tag  = tag_q.pop_front();
      check(meas == expv, tag, "half period", meas, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n || !bus_en) begin
      have_lead  = 0;
      have_trail = 0;
    end else begin
      if (trail) begin
        check(!sclk, "R5", "level at falling strobe", int'(sclk), 0);
        if (have_lead) score(cyc - t_lead);
        have_trail = 1;
        t_trail    = cyc;
      end
      if (lead) begin
        check(sclk, "R5", "level at rising strobe", int'(sclk), 1);
        if (have_trail) score(cyc - t_trail);
        have_lead = 1;
        t_lead    = cyc;
      end
    end
  end

  // Driver tasks
  task automatic wr(logic [CFG_W-1:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_en(bit v);
    @(posedge clk); #1;
    bus_en = v;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
  endtask

  task automatic push_exp(int h, int k, string req);
    for (int i = 0; i < k; i++) begin
      exp_q.push_back(h);
      tag_q.push_back(req);
    end
  endtask

  task automatic run_div(bit lin, int e, int n, int h, int k, string req);
    set_en(0);
    wr(enc(lin, e, n));
    set_en(1);
    push_exp(h, k, req);
    drain();
    set_en(0);
  endtask

  task automatic check_pass(int ncyc, string req);
    @(posedge clk);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      check(lead && sclk && !trail, req, "pass-through tick {lead,sclk,trail}",
            int'({lead, sclk, trail}), 6);
    end
  endtask

  task automatic check_idle(int ncyc, string req);
    @(posedge clk);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      check(!lead && !sclk && !trail, req, "idle {lead,sclk,trail}",
            int'({lead, sclk, trail}), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, actual %0d expected %0d pending items", exp_q.size(), 0);
    report();
    $finish;
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    check(!sclk, "R8", "sclk in reset", int'(sclk), 0);
    check(!lead, "R8", "lead strobe in reset", int'(lead), 0);
    check(!trail, "R8", "trail strobe in reset", int'(trail), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R8 + R4: the reset configuration is pass-through
    set_en(1);
    check_pass(8, "R4");
    set_en(0);

    // R7: idle, and a write while idle does not start the clock
    check_idle(3, "R7");
    wr(enc(1, 0, 2));
    check_idle(4, "R7");

    // R2 linear scheme
    run_div(1, 0, 0, 1, 6, "R2");
    run_div(1, 0, 5, 6, 4, "R2");
    run_div(1, 0, 255, 256, 3, "R2");

    // R3 power-of-two scheme, including the largest exponent
    run_div(0, 1, 0, 1, 6, "R3");
    run_div(0, 3, 0, 4, 4, "R3");
    run_div(0, 15, 0, 16384, 1, "R3");

    // R1 and R9: both fields populated, the select picks one
    run_div(1, 4, 2, 3, 4, "R1");
    run_div(0, 4, 2, 8, 4, "R9");
    set_en(0);
    wr(enc(0, 0, 77));
    set_en(1);
    check_pass(4, "R9");
    set_en(0);

    // R6: write during a high half; that half keeps its old length
    wr(enc(1, 0, 3));
    set_en(1);
    push_exp(4, 3, "R6");
    drain();
    @(negedge clk);
    while (!lead) @(negedge clk);
    wr(enc(1, 0, 1));
    exp_q.push_back(4); tag_q.push_back("R6");
    push_exp(2, 3, "R6");
    drain();
    set_en(0);
    check_idle(2, "R7");

    check(exp_q.size() == 0, "R6", "unscored items", exp_q.size(), 0);
    report();
    $finish;
  end

endmodule